// File: doc/BRIEF.md
# Configurable Byte-Parity Generator and Checker

This block sits on one port of a 36-bit data path made of four 9-bit byte lanes. The top bit of each lane is a parity bit over the lane's eight lower bits. Each word on the input bus is checked for parity errors. The block reports any error on a single active-high flag. It can also rewrite each lane's parity bit on the way through, so that the outgoing word carries fresh parity.

A four-bit control register sets how the block behaves. One bit selects even or odd parity. A second bit enables in-line regeneration of the parity bits. A third bit chooses between an error flag that follows the bus combinationally and one captured on the port clock. The fourth bit decides whether the check always covers all four lanes, or only the lanes that the 2-bit width-select input marks as active. Writes to the control register land on the next port clock edge. Reset is synchronous and active low.

Top module: `byte_parity_port`

## Requirements
- R1: While reset is low at a clock edge, the control register clears to all zeros. This gives even parity, generation off, a combinational flag and full-word checking. The captured flag also clears to 0.
- R2: With cfg_we high at a clock edge, the register loads cfg_wdata. Bit 0 selects odd parity, bit 1 enables generation, bit 2 selects the captured flag and bit 3 selects width-dependent checking. Until that edge the previous setting stays in force.
- R3: In even mode, a lane is in error when its nine bits hold an odd number of ones.
- R4: In odd mode, a lane is in error when its nine bits hold an even number of ones.
- R5: With generation off, dout equals din bit for bit.
- R6: With generation on, bit 8 of each lane (bit 9k+8 for lane k) is replaced by a value that makes that lane correct under the current parity sense. The eight lower bits of each lane pass unchanged.
- R7: The check is made on din as received, before any parity bit is rewritten.
- R8: With the combinational flag selected, perr reflects the current din within the same cycle.
- R9: With the captured flag selected, perr shows the error state sampled at the most recent clock edge and holds it between edges.
- R10: In full-word mode, all four lanes are checked whatever the value of wsel.
- R11: In width-dependent mode, wsel 00 checks all four lanes, wsel 01 checks lanes 0 and 1 (din[17:0]), and wsel 10 or 11 checks lane 0 only (din[8:0]).
- R12: perr is high exactly when at least one checked lane is in error. An error in an unchecked lane does not affect perr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 4 | Control value: {width_dep, latch_flag, gen_en, odd} |
| wsel | input | 2 | Width select for the active lanes |
| din | input | 36 | Incoming data word, four 9-bit lanes |
| dout | output | 36 | Outgoing word, with parity bits optionally regenerated |
| perr | output | 1 | Parity error flag, active high |

## Verification
On every cycle the checker confirms several properties. The output equals the input when generation is off. Regenerated lanes are always correct under the active sense, and lower data bits are never altered. The flag tracks the selected-lane error immediately in combinational mode and one edge late in captured mode. The lane selection matches the full-word and single-lane cases, and the register clears after reset. Other behaviour depends on a known stimulus and can only be shown by the bench's scenarios. This covers whether the even and odd senses classify a given word correctly, and the exact cycle at which a control write takes effect. It also covers errors in unchecked lanes being ignored in the half-word case, and the flag judging the incoming word rather than the rewritten one.

// File: rtl/bpp_pkg.sv
// Package: shared widths and the control-register layout for the
// byte-parity port. Assumes lanes are equal width with parity on top.
package bpp_pkg;

    localparam int unsigned BPP_LANE_W  = 9;
    localparam int unsigned BPP_LANES   = 4;
    localparam int unsigned BPP_CFG_W   = 4;

    // Control register fields, MSB first: bit3..bit0
    typedef struct packed {
        logic width_dep;   // 1: check only lanes chosen by wsel
        logic latch_flag;  // 1: error flag captured on clk
        logic gen_en;      // 1: rewrite parity bits on the way out
        logic odd;         // 1: odd parity sense
    } bpp_cfg_t;

    // Width-select codes
    localparam logic [1:0] BPP_WSEL_FULL = 2'b00;
    localparam logic [1:0] BPP_WSEL_HALF = 2'b01;

endpackage

// File: rtl/bpp_cfg_reg.sv
// Module: bpp_cfg_reg
// Holds the four control bits. Loads on a write strobe at the clock
// edge. Clears on synchronous active-low reset.
// Assumes the writer holds cfg_wdata valid while cfg_we is high.
module bpp_cfg_reg
    import bpp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [BPP_CFG_W-1:0] wdata,
    output bpp_cfg_t             cfg
);

    bpp_cfg_t cfg_q;

    // Register update: clear on reset, load on write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= bpp_cfg_t'(wdata);
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/bpp_lane.sv
// Module: bpp_lane
// One byte lane. Flags a parity error on the incoming lane under the
// chosen sense. Optionally replaces the top bit with regenerated parity.
// Assumes the parity bit is the lane MSB and covers all lower bits.
module bpp_lane #(
    parameter int unsigned LANE_W = 9
) (
    input  logic [LANE_W-1:0] lane_in,
    input  logic              odd,
    input  logic              gen_en,
    output logic [LANE_W-1:0] lane_out,
    output logic              lane_err
);

    localparam int unsigned DATA_W = LANE_W - 1;

    logic data_par;
    logic gen_bit;

    // Error and regenerated-bit computation for this lane
    always_comb begin
        data_par = ^lane_in[DATA_W-1:0];
        gen_bit  = data_par ^ odd;
        lane_err = data_par ^ lane_in[DATA_W] ^ odd;
    end

    // Output assembly: data bits pass, parity bit optionally replaced
    always_comb begin
        lane_out[DATA_W-1:0] = lane_in[DATA_W-1:0];
        lane_out[DATA_W]     = gen_en ? gen_bit : lane_in[DATA_W];
    end

endmodule

// File: rtl/bpp_range_mask.sv
// Module: bpp_range_mask
// Chooses which lanes take part in the check. Full-word mode enables
// every lane. Width-dependent mode follows wsel: all lanes, the lower
// half, or lane 0 alone. Assumes LANES is even and at least 2.
module bpp_range_mask
    import bpp_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic [1:0]       wsel,
    input  logic             width_dep,
    output logic [LANES-1:0] mask
);

    localparam int unsigned HALF = LANES / 2;

    logic [LANES-1:0] half_mask;
    logic [LANES-1:0] one_mask;

    // Fixed lane patterns for the half-word and single-lane cases
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            half_mask[i] = (i < HALF);
            one_mask[i]  = (i == 0);
        end
    end

    // Lane selection by mode and width select
    always_comb begin
        if (!width_dep) begin
            mask = '1;
        end else begin
            case (wsel)
                BPP_WSEL_FULL: mask = '1;
                BPP_WSEL_HALF: mask = half_mask;
                default:       mask = one_mask;
            endcase
        end
    end

endmodule

// File: rtl/bpp_err_flag.sv
// Module: bpp_err_flag
// Combines lane errors under the lane mask. Drives the flag either
// straight through or from a register captured on clk.
// Assumes lane_err and mask come from the same word.
module bpp_err_flag #(
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_err,
    input  logic [LANES-1:0] mask,
    input  logic             latch_flag,
    output logic             sel_err,
    output logic             flag
);

    logic flag_q;

    // Reduce the masked lane errors to one bit
    always_comb begin
        sel_err = |(lane_err & mask);
    end

    // Capture register, updated every edge so that a mode switch sees fresh data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= sel_err;
        end
    end

    // Output select between captured and flow-through flag
    always_comb begin
        flag = latch_flag ? flag_q : sel_err;
    end

endmodule

// File: rtl/byte_parity_port.sv
// Module: byte_parity_port (top)
// Parity generator and checker for one port of a lane-organised data path.
// Builds one lane instance per byte, a lane-selection mask, the flag
// stage and the control register.
// Assumes din is stable around the clock edge when the flag is captured.
module byte_parity_port
    import bpp_pkg::*;
#(
    parameter int unsigned LANE_W = BPP_LANE_W,
    parameter int unsigned LANES  = BPP_LANES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [BPP_CFG_W-1:0]      cfg_wdata,
    input  logic [1:0]                wsel,
    input  logic [LANE_W*LANES-1:0]   din,
    output logic [LANE_W*LANES-1:0]   dout,
    output logic                      perr
);

    localparam int unsigned WORD_W = LANE_W * LANES;

    bpp_cfg_t         cfg_q;
    logic [LANES-1:0] lane_err;
    logic [LANES-1:0] lane_mask;
    logic             flag_comb;

    // Control register
    bpp_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    // One lane per byte
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        bpp_lane #(.LANE_W(LANE_W)) u_lane (
            .lane_in  (din[k*LANE_W +: LANE_W]),
            .odd      (cfg_q.odd),
            .gen_en   (cfg_q.gen_en),
            .lane_out (dout[k*LANE_W +: LANE_W]),
            .lane_err (lane_err[k])
        );
    end

    // Lane selection
    bpp_range_mask #(.LANES(LANES)) u_mask (
        .wsel      (wsel),
        .width_dep (cfg_q.width_dep),
        .mask      (lane_mask)
    );

    // Error flag
    bpp_err_flag #(.LANES(LANES)) u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_err   (lane_err),
        .mask       (lane_mask),
        .latch_flag (cfg_q.latch_flag),
        .sel_err    (flag_comb),
        .flag       (perr)
    );

    if (WORD_W < 2) begin : g_bad_width
        initial $error("byte_parity_port: word too narrow");
    end

endmodule

// File: rtl/bpp_chk.sv
// Module: bpp_chk
// Property checker for byte_parity_port. It is attached through bind
// and observes the ports, the control register and the lane error
// vector together with the selected-error signal.
module bpp_chk
    import bpp_pkg::*;
#(
    parameter int unsigned LANE_W = 9,
    parameter int unsigned LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              wsel,
    input  logic [LANE_W*LANES-1:0] din,
    input  logic [LANE_W*LANES-1:0] dout,
    input  logic                    perr,
    input  bpp_cfg_t                cfg,
    input  logic [LANES-1:0]        lane_err,
    input  logic                    sel_err
);

    logic [LANES-1:0] out_bad;
    logic             low_same;

    // Lane health of the outgoing word and equality of the lower data bits
    always_comb begin
        low_same = 1'b1;
        for (int k = 0; k < LANES; k++) begin
            out_bad[k] = (^dout[k*LANE_W +: LANE_W]) ^ cfg.odd;
            if (dout[k*LANE_W +: LANE_W-1] != din[k*LANE_W +: LANE_W-1])
                low_same = 1'b0;
        end
    end

    // R1
    cfg_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg == '0));

    // R5
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.gen_en |-> (dout == din));

    // R6
    gen_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.gen_en |-> (out_bad == '0));

    // R6
    low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_same);

    // R8
    flow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.latch_flag |-> (perr == sel_err));

    // R9
    latched_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.latch_flag && $past(rst_n)) |-> (perr == $past(sel_err)));

    // R10
    full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.width_dep |-> (sel_err == (|lane_err)));

    // R11
    one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.width_dep && wsel[1]) |-> (sel_err == lane_err[0]));

endmodule

bind byte_parity_port bpp_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wsel     (wsel),
    .din      (din),
    .dout     (dout),
    .perr     (perr),
    .cfg      (cfg_q),
    .lane_err (lane_err),
    .sel_err  (flag_comb)
);

// File: tb/tb_byte_parity_port.sv
`timescale 1ns/1ps
module tb_byte_parity_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_wdata = 4'h0;
    logic [1:0]  wsel = 2'b00;
    logic [35:0] din = '0;
    logic [35:0] dout;
    logic        perr;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    byte_parity_port dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .wsel(wsel), .din(din), .dout(dout), .perr(perr)
    );

    // Build a word from four data bytes; bad[k] spoils lane k under sense odd
    function automatic logic [35:0] mk(input logic [31:0] lows, input logic [3:0] bad,
                                       input logic odd);
        logic [35:0] w;
        for (int k = 0; k < 4; k++) begin
            w[k*9 +: 8] = lows[k*8 +: 8];
            w[k*9 + 8]  = (^lows[k*8 +: 8]) ^ odd ^ bad[k];
        end
        return w;
    endfunction

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [3:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R1: reset clears config even if a write is presented during reset
    task automatic t_reset();
        rst_n = 1'b0; cfg_we = 1'b1; cfg_wdata = 4'hF;
        repeat (3) @(negedge clk);
        cfg_we = 1'b0; rst_n = 1'b1;
        din = mk(32'hA5C3_0F11, 4'b0100, 1'b0);
        #1;
        chk("R1 gen off after reset", dout, din);
        chk("R1 flow-through even after reset", {35'd0, perr}, 36'd1);
    endtask

    // R3: even sense classification
    task automatic t_even();
        @(negedge clk);
        din = mk(32'h1234_5678, 4'b0000, 1'b0); #1;
        chk("R3 clean even word", {35'd0, perr}, 36'd0);
        din = mk(32'hFFFF_FFFF, 4'b1000, 1'b0); #1;
        chk("R3 lane3 odd count", {35'd0, perr}, 36'd1);
    endtask

    // R2 and R4: odd sense takes effect at the write edge
    task automatic t_odd();
        @(negedge clk);
        din = mk(32'h0000_0000, 4'b0000, 1'b0);
        cfg_we = 1'b1; cfg_wdata = 4'b0001; #1;
        chk("R2 old setting before edge", {35'd0, perr}, 36'd0);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        chk("R2 R4 even word fails in odd mode", {35'd0, perr}, 36'd1);
        din = mk(32'hDEAD_BEEF, 4'b0000, 1'b1); #1;
        chk("R4 clean odd word", {35'd0, perr}, 36'd0);
        din = mk(32'hDEAD_BEEF, 4'b0010, 1'b1); #1;
        chk("R4 lane1 bad in odd mode", {35'd0, perr}, 36'd1);
    endtask

    // R5 R6 R7: regeneration and checking on incoming data
    task automatic t_gen();
        logic [35:0] w;
        wr_cfg(4'b0010);
        w = mk(32'h8001_7E3C, 4'b1011, 1'b0);
        din = w; #1;
        chk("R6 even regen", dout, mk(32'h8001_7E3C, 4'b0000, 1'b0));
        chk("R7 error seen before rewrite", {35'd0, perr}, 36'd1);
        wr_cfg(4'b0011);
        din = w; #1;
        chk("R6 odd regen", dout, mk(32'h8001_7E3C, 4'b0000, 1'b1));
        wr_cfg(4'b0000);
        din = w; #1;
        chk("R5 passthrough", dout, w);
    endtask

    // R9: captured flag follows edges, holds between them
    task automatic t_latched();
        wr_cfg(4'b0100);
        din = mk(32'h1111_2222, 4'b0000, 1'b0);
        @(posedge clk); #1;
        chk("R9 captured clean", {35'd0, perr}, 36'd0);
        din = mk(32'h1111_2222, 4'b0001, 1'b0); #1;
        chk("R9 holds until edge", {35'd0, perr}, 36'd0);
        @(posedge clk); #1;
        chk("R9 captured error", {35'd0, perr}, 36'd1);
        din = mk(32'h1111_2222, 4'b0000, 1'b0); #1;
        chk("R9 holds error until edge", {35'd0, perr}, 36'd1);
        @(posedge clk); #1;
        chk("R9 cleared at edge", {35'd0, perr}, 36'd0);
    endtask

    // R8 R10 R11 R12: lane selection
    task automatic t_width();
        wr_cfg(4'b0000);
        wsel = 2'b10;
        din = mk(32'hCAFE_F00D, 4'b1000, 1'b0); #1;
        chk("R10 full-word ignores wsel", {35'd0, perr}, 36'd1);
        chk("R8 flow-through same cycle", {35'd0, perr}, 36'd1);
        wr_cfg(4'b1000);
        wsel = 2'b00; #1;
        chk("R11 wsel00 sees lane3", {35'd0, perr}, 36'd1);
        wsel = 2'b01; #1;
        chk("R12 wsel01 ignores lane3", {35'd0, perr}, 36'd0);
        din = mk(32'hCAFE_F00D, 4'b0010, 1'b0); #1;
        chk("R11 wsel01 sees lane1", {35'd0, perr}, 36'd1);
        wsel = 2'b10; #1;
        chk("R12 wsel10 ignores lane1", {35'd0, perr}, 36'd0);
        wsel = 2'b11;
        din = mk(32'hCAFE_F00D, 4'b0001, 1'b0); #1;
        chk("R11 wsel11 sees lane0", {35'd0, perr}, 36'd1);
        din = mk(32'hCAFE_F00D, 4'b1110, 1'b0); #1;
        chk("R12 wsel11 ignores lanes1-3", {35'd0, perr}, 36'd0);
    endtask

    initial begin
        t_reset();
        t_even();
        t_odd();
        t_gen();
        t_latched();
        t_width();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule